// File: doc/BRIEF.md
# Dual-Edge Retriggerable One-Shot Timer

This block is a clocked monostable pulse generator. It measures its pulse with a counter of clock cycles, where a discrete design would use a resistor and a capacitor. A pulse can be started in two ways: by a rising edge on the leading-edge trigger input, or by a falling edge on the trailing-edge trigger input. Each trigger is qualified by the level of the other input, so an unused input held at its idle level leaves the remaining input fully functional. The pulse length is a cycle count taken from the `period` port when a trigger is accepted.

A mode input chooses what happens to triggers that arrive during a pulse. In extend mode each accepted trigger reloads the counter, so the output stays high until a full period has passed after the last trigger. In lockout mode the period runs from the first trigger and later triggers are ignored while the output is high. There are two ways to clear the block. A synchronous active-high reset returns it to its power-up state. An asynchronous active-low clear drops the output at once and holds it low.

Top module: `oneshot_timer`

## Requirements
- R1: A rising edge on `trig_rise` starts a pulse only if `trig_fall` is high at the same synchronized sample. A rising edge while `trig_fall` is low starts nothing.
- R2: A falling edge on `trig_fall` starts a pulse only if `trig_rise` is low at the same synchronized sample. A falling edge while `trig_rise` is high starts nothing.
- R3: `pulse_out_n` is the inverse of `pulse_out` in every cycle.
- R4: Suppose an input edge is applied between two clock edges. Then `pulse_out` goes high after the third following rising clock edge, whatever `period` holds, and stays high for exactly `period` cycles.
- R5: A trigger accepted while `period` is 0 produces no pulse.
- R6: With `retrig_en` = 1, a qualified trigger during a pulse reloads the count, so the pulse ends `period` cycles after the last trigger.
- R7: With `retrig_en` = 0, qualified triggers during a pulse have no effect, and the pulse lasts `period` cycles from the first trigger.
- R8: While `rst` is high at a clock edge, the block returns to the cleared state: `pulse_out` is low, no pulse is in progress, and both synchronizers hold their idle levels (`trig_rise` low, `trig_fall` high).
- R9: When `clr_n` goes low, `pulse_out` drops at once without waiting for a clock edge. Triggers that arrive while `clr_n` is low start no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_n | input | 1 | Asynchronous active-low clear of the pulse |
| trig_rise | input | 1 | Leading-edge trigger, idle low |
| trig_fall | input | 1 | Trailing-edge trigger, idle high |
| retrig_en | input | 1 | 1: extend on retrigger, 0: ignore triggers while active |
| period | input | PERIOD_W | Pulse length in clock cycles |
| pulse_out | output | 1 | True pulse output |
| pulse_out_n | output | 1 | Complementary pulse output |

## Verification
Single triggers are applied on each input with the opposite input at its qualifying level. The same edges are then applied with the opposite input at its blocking level, which shows that qualification is working and the block is not a bare edge detector. A second trigger is sent a few cycles into a running pulse, once in each mode, and the two resulting widths show whether the counter reloads or holds. Latency is measured with a short and a long period to show that the start delay does not depend on the count. Zero-period triggers and triggers sent during an asynchronous clear check the cases where no pulse must appear.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

    // Idle levels of the two trigger inputs
    localparam logic RISE_IDLE = 1'b0;
    localparam logic FALL_IDLE = 1'b1;

    typedef enum logic {
        MODE_LOCKOUT = 1'b0,
        MODE_EXTEND  = 1'b1
    } retrig_mode_e;

    typedef struct packed {
        logic rise_lvl;
        logic fall_lvl;
    } trig_pair_t;

    typedef struct packed {
        logic rise_hit;
        logic fall_hit;
    } trig_hits_t;

    function automatic trig_pair_t idle_pair();
        trig_pair_t p;
        p.rise_lvl = RISE_IDLE;
        p.fall_lvl = FALL_IDLE;
        return p;
    endfunction

endpackage

// File: rtl/os_sync.sv
module os_sync
    import oneshot_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  trig_pair_t din,
    output trig_pair_t dout
);

    trig_pair_t stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage[0] <= idle_pair();
        else     stage[0] <= din;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage[i] <= idle_pair();
            else     stage[i] <= stage[i-1];
        end
    end

    assign dout = stage[STAGES-1];

endmodule

// File: rtl/os_edge_qual.sv
module os_edge_qual
    import oneshot_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  trig_pair_t lvl,
    output trig_hits_t hits,
    output logic       fire
);

    trig_pair_t prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= idle_pair();
        else     prev <= lvl;
    end

    always_comb begin
        hits.rise_hit = lvl.rise_lvl & ~prev.rise_lvl & lvl.fall_lvl;
        hits.fall_hit = ~lvl.fall_lvl & prev.fall_lvl & ~lvl.rise_lvl;
    end

    assign fire = hits.rise_hit | hits.fall_hit;

    // R1: a leading-edge hit only follows a rise of the synchronized level
    assert_rise_edge_R1: assert property (@(posedge clk) disable iff (rst)
        hits.rise_hit |-> $rose(lvl.rise_lvl));

    // R2: a trailing-edge hit only follows a fall of the synchronized level
    assert_fall_edge_R2: assert property (@(posedge clk) disable iff (rst)
        hits.fall_hit |-> $fell(lvl.fall_lvl));

endmodule

// File: rtl/os_timer.sv
module os_timer
    import oneshot_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_n,
    input  logic         fire,
    input  retrig_mode_e mode,
    input  logic [W-1:0] period,
    output logic         active
);

    localparam logic [W-1:0] ZERO = '0;
    localparam logic [W-1:0] ONE  = W'(1);

    logic [W-1:0] remain;
    logic         load;

    assign active = (remain != ZERO);
    assign load   = fire && (!active || mode == MODE_EXTEND);

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)      remain <= ZERO;
        else if (rst)    remain <= ZERO;
        else if (load)   remain <= period;
        else if (active) remain <= remain - ONE;
    end

    // R4: an idle timer that accepts a trigger holds the requested count
    assert_load_R4: assert property (@(posedge clk) disable iff (rst || !clr_n)
        (fire && !active) |=> remain == $past(period));

    // R5: a zero count leaves the timer idle
    assert_zero_period_R5: assert property (@(posedge clk) disable iff (rst || !clr_n)
        (fire && !active && period == ZERO) |=> !active);

    // R6: extend mode reloads on every trigger during a pulse
    assert_reload_R6: assert property (@(posedge clk) disable iff (rst || !clr_n)
        (fire && active && mode == MODE_EXTEND) |=> remain == $past(period));

    // R7: lockout mode keeps counting down through triggers
    assert_lockout_R7: assert property (@(posedge clk) disable iff (rst || !clr_n)
        (active && (!fire || mode == MODE_LOCKOUT)) |=> remain == $past(remain) - ONE);

endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer
    import oneshot_pkg::*;
#(
    parameter int PERIOD_W    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr_n,
    input  logic                trig_rise,
    input  logic                trig_fall,
    input  logic                retrig_en,
    input  logic [PERIOD_W-1:0] period,
    output logic                pulse_out,
    output logic                pulse_out_n
);

    trig_pair_t   raw_lvl;
    trig_pair_t   sync_lvl;
    trig_hits_t   hits;
    logic         fire;
    logic         active;
    retrig_mode_e mode;

    assign raw_lvl.rise_lvl = trig_rise;
    assign raw_lvl.fall_lvl = trig_fall;
    assign mode = retrig_en ? MODE_EXTEND : MODE_LOCKOUT;

    os_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_lvl),
        .dout (sync_lvl)
    );

    os_edge_qual u_qual (
        .clk  (clk),
        .rst  (rst),
        .lvl  (sync_lvl),
        .hits (hits),
        .fire (fire)
    );

    os_timer #(.W(PERIOD_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .clr_n  (clr_n),
        .fire   (fire),
        .mode   (mode),
        .period (period),
        .active (active)
    );

    assign pulse_out   = active;
    assign pulse_out_n = ~active;

    // R4: a pulse only begins after an accepted trigger
    assert_start_needs_fire_R4: assert property (@(posedge clk) disable iff (rst || !clr_n)
        $rose(pulse_out) |-> $past(fire));

    // R8: a synchronous reset leaves the output low
    assert_reset_clears_R8: assert property (@(posedge clk) disable iff (!clr_n)
        rst |=> !pulse_out);

endmodule

// File: tb/oneshot_timer_test.sv
module oneshot_timer_test;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         clr_n = 1'b1;
    logic         a = 1'b0;
    logic         b = 1'b1;
    logic         mode = 1'b1;
    logic [W-1:0] per = 8'd5;
    logic         q;
    logic         qn;

    always #5 clk = ~clk;

    oneshot_timer #(.PERIOD_W(W), .SYNC_STAGES(2)) uut (
        .clk         (clk),
        .rst         (rst),
        .clr_n       (clr_n),
        .trig_rise   (a),
        .trig_fall   (b),
        .retrig_en   (mode),
        .period      (per),
        .pulse_out   (q),
        .pulse_out_n (qn)
    );

    int    checks = 0;
    int    fails  = 0;
    int    hi_cnt = 0;
    int    rem    = 0;
    string tag    = "R8";
    bit    a1 = 0, a2 = 0, a3 = 0;
    bit    b1 = 1, b2 = 1, b3 = 1;
    bit    ended = 0;

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Behavioural reference: input history and remaining pulse cycles
    always @(posedge clk) begin
        bit tr;
        tr = (a2 && !a3 && b2) || (!b2 && b3 && !a2);
        if (rst || !clr_n)              rem = 0;
        else if (tr && (rem == 0 || mode)) rem = int'(per);
        else if (rem > 0)               rem = rem - 1;
        a3 = a2; a2 = a1; b3 = b2; b2 = b1;
        a1 = rst ? 1'b0 : a;
        b1 = rst ? 1'b1 : b;
        #2;
        check(q == (rem != 0), tag, "pulse_out", int'(q), int'(rem != 0));
        check(qn == ~q, "R3", "pulse_out_n", int'(qn), int'(~q));
        if (q) hi_cnt++;
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_a();
        @(negedge clk) a = 1'b1;
        @(negedge clk) a = 1'b0;
    endtask

    task automatic pulse_b();
        @(negedge clk) b = 1'b0;
        @(negedge clk) b = 1'b1;
    endtask

    task automatic latency(logic [W-1:0] n, string req);
        int k;
        @(negedge clk);
        per = n;
        a = 1'b1;
        k = 0;
        do begin
            @(posedge clk);
            #3;
            k++;
        end while (!q && k < 10);
        check(k == 3, req, "start latency", k, 3);
        @(negedge clk) a = 1'b0;
        idle(int'(n) + 4);
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        idle(4);
        check(q == 1'b0, "R8", "pulse_out in reset", int'(q), 0);
        check(qn == 1'b1, "R8", "pulse_out_n in reset", int'(qn), 1);
        @(negedge clk) rst = 1'b0;
        idle(3);

        // R1: qualified leading edge, width = period
        tag = "R1"; per = 8'd5; hi_cnt = 0;
        pulse_a(); idle(15);
        check(hi_cnt == 5, "R1", "pulse width", hi_cnt, 5);

        // R2: qualified trailing edge
        tag = "R2"; per = 8'd7; hi_cnt = 0;
        pulse_b(); idle(15);
        check(hi_cnt == 7, "R2", "pulse width", hi_cnt, 7);

        // R1/R2 blocked edges: no pulse expected
        tag = "R1"; hi_cnt = 0;
        @(negedge clk) begin a = 1'b1; b = 1'b0; end
        idle(4);
        @(negedge clk) a = 1'b0;
        idle(4);
        @(negedge clk) a = 1'b1;
        idle(6);
        check(hi_cnt == 0, "R1", "blocked leading edge", hi_cnt, 0);
        tag = "R2";
        @(negedge clk) b = 1'b1;
        idle(4);
        @(negedge clk) b = 1'b0;
        idle(6);
        @(negedge clk) b = 1'b1;
        idle(4);
        @(negedge clk) a = 1'b0;
        idle(6);
        check(hi_cnt == 0, "R2", "blocked trailing edge", hi_cnt, 0);

        // R4: latency independent of period
        tag = "R4";
        latency(8'd3, "R4");
        latency(8'd40, "R4");
        hi_cnt = 0; per = 8'd1;
        pulse_b(); idle(8);
        check(hi_cnt == 1, "R4", "one-cycle pulse", hi_cnt, 1);

        // R5: zero period
        tag = "R5"; per = 8'd0; hi_cnt = 0;
        pulse_a(); idle(6); pulse_b(); idle(8);
        check(hi_cnt == 0, "R5", "zero period width", hi_cnt, 0);

        // R6: extend mode, retrigger 4 cycles after the first
        tag = "R6"; mode = 1'b1; per = 8'd8; hi_cnt = 0;
        pulse_a(); idle(2); pulse_a(); idle(20);
        check(hi_cnt == 12, "R6", "extended width", hi_cnt, 12);

        // R7: lockout mode, same stimulus
        tag = "R7"; mode = 1'b0; hi_cnt = 0;
        pulse_a(); idle(2); pulse_a(); idle(20);
        check(hi_cnt == 8, "R7", "lockout width", hi_cnt, 8);
        hi_cnt = 0;
        pulse_a(); idle(1); pulse_b(); idle(20);
        check(hi_cnt == 8, "R7", "lockout width, mixed triggers", hi_cnt, 8);
        mode = 1'b1;

        // R9: asynchronous clear mid-pulse, triggers during clear ignored
        tag = "R9"; per = 8'd20; hi_cnt = 0;
        pulse_a(); idle(5);
        @(negedge clk);
        #1;
        clr_n = 1'b0;
        rem = 0;
        #1;
        check(q == 1'b0, "R9", "pulse_out right after clear", int'(q), 0);
        pulse_a(); idle(8);
        @(negedge clk) clr_n = 1'b1;
        idle(4);
        check(q == 1'b0, "R9", "no pulse from trigger during clear", int'(q), 0);
        hi_cnt = 0; per = 8'd4;
        pulse_b(); idle(10);
        check(hi_cnt == 4, "R9", "trigger after clear release", hi_cnt, 4);

        // R8: synchronous reset during a pulse
        tag = "R8"; per = 8'd30;
        pulse_a(); idle(4);
        @(negedge clk) rst = 1'b1;
        idle(3);
        check(q == 1'b0, "R8", "pulse_out after reset", int'(q), 0);
        @(negedge clk) rst = 1'b0;
        idle(5);

        finish_run();
    end

endmodule